// File: doc/BRIEF.md
# Receiver Channel Reset Sequencer

This block drives the two reset lines of a serial receiver channel whose clock-and-data recovery unit locks by itself. It runs on the recovered parallel clock. Its status inputs are a calibration/reconfiguration busy flag and a frequency-lock flag. From these it decides when the analog front end may leave reset and, later, when the digital datapath may follow.

After a reset request, both resets are held for as long as calibration is busy. A short fixed guard follows, and then the analog reset is released. The digital reset stays on until the recovery unit reports frequency lock, and lock must then hold for a programmable dwell time. Only after that is the digital reset released and the ready flag raised. If lock is lost during the dwell, the dwell starts again. If lock is lost after release, the digital reset is reasserted. Busy may be low from the start, as happens on a reset that is not the first one after power-up.

Top module: `rx_reset_seq`

## Requirements
- R1: While the synchronized busy flag is high and the analog reset has not yet been released, both `rx_analog_rst` and `rx_digital_rst` stay at 1 and `rx_ready` stays at 0. Out of reset, the synchronized busy value is taken as 1.
- R2: `busy_in` and `lock_in` each pass through `SYNC_STAGES` (default 2) flops before the sequencer uses them. The sequencer leaves the hold state on the first edge where synchronized busy is low. It then spends exactly `GUARD_CYCLES` (default 2) cycles in the guard state, and `rx_analog_rst` drops on the edge that ends the guard.
- R3: After the analog reset is released, `rx_digital_rst` stays at 1 until synchronized lock is seen high. Busy is ignored from this point on.
- R4: Once synchronized lock is seen, `rx_digital_rst` drops after `DWELL_CYCLES` (default 20) consecutive cycles with lock high.
- R5: If synchronized lock goes low during the dwell, the sequencer goes back to waiting for lock, and the dwell count starts from zero at the next lock.
- R6: If synchronized lock goes low while ready, `rx_digital_rst` returns to 1 and `rx_ready` to 0 on the next edge, and the sequencer waits for lock again. `rx_analog_rst` stays at 0.
- R7: `rx_ready` is a registered output. It is 1 exactly when both resets are 0.
- R8: A clock edge with `rst_req` high puts the sequencer in its initial state: `rx_analog_rst`=1, `rx_digital_rst`=1, `rx_ready`=0.
- R9: If synchronized busy rises again during the guard, the sequencer returns to the hold state. It releases nothing and repeats the full guard after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel (recovered) clock |
| rst_req | input | 1 | Synchronous reset request, active high |
| busy_in | input | 1 | Calibration/reconfiguration busy flag, asynchronous |
| lock_in | input | 1 | Frequency-lock flag from the recovery unit, asynchronous |
| rx_analog_rst | output | 1 | Receiver analog reset, active high |
| rx_digital_rst | output | 1 | Receiver digital reset, active high |
| rx_ready | output | 1 | Receiver ready for data |

## Verification
The bench goes after the exact release edge of the analog reset. A guard that is one cycle off, or a missing synchronizer stage, moves the release by one edge, and the per-cycle comparison catches this. Lock glitches are placed inside the dwell. A design that kept its count across a glitch would release the digital reset too early. Busy pulses during the guard and lock drops while ready are also injected. A design that missed them would keep the analog release or keep ready high on a channel that has lost lock. Episodes in which busy is low from the first cycle check that the sequencer does not wait for a busy pulse that never arrives.

// File: rtl/rx_reset_seq.sv
module rx_reset_seq #(
  parameter int GUARD_CYCLES = 2,
  parameter int DWELL_CYCLES = 20,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_req,
  input  logic busy_in,
  input  logic lock_in,
  output logic rx_analog_rst,
  output logic rx_digital_rst,
  output logic rx_ready
);

  localparam int MAXC = (GUARD_CYCLES > DWELL_CYCLES) ? GUARD_CYCLES : DWELL_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {
    ST_HOLD, ST_GUARD, ST_WAIT_LOCK, ST_DWELL, ST_READY
  } seq_state_t;

  logic [SYNC_STAGES-1:0] busy_pipe, lock_pipe;
  logic busy_s, lock_s;

  always_ff @(posedge clk) begin
    if (rst_req) begin
      busy_pipe <= '1;
      lock_pipe <= '0;
    end else begin
      busy_pipe <= {busy_pipe[SYNC_STAGES-2:0], busy_in};
      lock_pipe <= {lock_pipe[SYNC_STAGES-2:0], lock_in};
    end
  end

  assign busy_s = busy_pipe[SYNC_STAGES-1];
  assign lock_s = lock_pipe[SYNC_STAGES-1];

  seq_state_t state, nxt;
  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_HOLD:      if (!busy_s) nxt = ST_GUARD;
      ST_GUARD:     if (busy_s) nxt = ST_HOLD;
                    else if (cnt == CW'(GUARD_CYCLES - 1)) nxt = ST_WAIT_LOCK;
      ST_WAIT_LOCK: if (lock_s) nxt = ST_DWELL;
      ST_DWELL:     if (!lock_s) nxt = ST_WAIT_LOCK;
                    else if (cnt == CW'(DWELL_CYCLES - 1)) nxt = ST_READY;
      ST_READY:     if (!lock_s) nxt = ST_WAIT_LOCK;
      default:      nxt = ST_HOLD;
    endcase
  end

  assign cnt_nxt = (nxt != state) ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst_req) begin
      state          <= ST_HOLD;
      cnt            <= '0;
      rx_analog_rst  <= 1'b1;
      rx_digital_rst <= 1'b1;
      rx_ready       <= 1'b0;
    end else begin
      state          <= nxt;
      cnt            <= (nxt == ST_GUARD || nxt == ST_DWELL) ? cnt_nxt : '0;
      rx_analog_rst  <= (nxt == ST_HOLD) || (nxt == ST_GUARD);
      rx_digital_rst <= (nxt != ST_READY);
      rx_ready       <= (nxt == ST_READY);
    end
  end

  p_hold_busy_r1: assert property (@(posedge clk) disable iff (rst_req)
    (rx_analog_rst && busy_s) |=> (rx_analog_rst && rx_digital_rst && !rx_ready));

  p_guard_quiet_r2: assert property (@(posedge clk) disable iff (rst_req)
    $fell(rx_analog_rst) |-> ($past(!busy_s, 1) && $past(!busy_s, 2)));

  p_order_r3: assert property (@(posedge clk) disable iff (rst_req)
    !rx_digital_rst |-> !rx_analog_rst);

  p_lock_seen_r4: assert property (@(posedge clk) disable iff (rst_req)
    $fell(rx_digital_rst) |-> $past(lock_s));

  p_lock_drop_r6: assert property (@(posedge clk) disable iff (rst_req)
    (rx_ready && !lock_s) |=> (rx_digital_rst && !rx_ready && !rx_analog_rst));

  p_ready_both_r7: assert property (@(posedge clk) disable iff (rst_req)
    rx_ready == (!rx_digital_rst && !rx_analog_rst));

  p_reset_r8: assert property (@(posedge clk)
    rst_req |=> (rx_analog_rst && rx_digital_rst && !rx_ready));

  initial begin
    a_params_r2: assert (GUARD_CYCLES >= 1 && DWELL_CYCLES >= 1 && SYNC_STAGES >= 2);
  end

endmodule

// File: tb/rx_reset_seq_tb.sv
`timescale 1ns/1ps
module rx_reset_seq_tb;
  localparam int G = 2;
  localparam int D = 20;

  logic clk = 1'b0;
  logic rst_req = 1'b1;
  logic busy_in = 1'b1;
  logic lock_in = 1'b0;
  logic rx_analog_rst, rx_digital_rst, rx_ready;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_reset_seq #(.GUARD_CYCLES(G), .DWELL_CYCLES(D), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_req(rst_req), .busy_in(busy_in), .lock_in(lock_in),
    .rx_analog_rst(rx_analog_rst), .rx_digital_rst(rx_digital_rst), .rx_ready(rx_ready));

  // Reference built from the requirements: two-stage input delay, phase, remaining-cycle timer
  bit b1, b2, l1, l2;
  int phase, remain;
  bit from_guard, restarted, dropped, in_rst;

  function automatic string tag_of(int ph, bit rs, bit fg, bit rst_, bit dr);
    if (rs) return "R8";
    case (ph)
      0: return fg ? "R9" : "R1";
      1: return "R2";
      2: return dr ? "R6" : "R3";
      3: return rst_ ? "R5" : "R4";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [2:0] expect_out(int ph);
    return {ph < 2, ph != 4, ph == 4};
  endfunction

  task automatic model_step();
    if (rst_req) begin
      phase = 0; remain = 0; b1 = 1; b2 = 1; l1 = 0; l2 = 0;
      from_guard = 0; restarted = 0; dropped = 0; in_rst = 1;
    end else begin
      in_rst = 0;
      case (phase)
        0: if (!b2) begin phase = 1; remain = G; end
        1: if (b2) begin phase = 0; from_guard = 1; end
           else if (remain == 1) phase = 2;
           else remain--;
        2: if (l2) begin phase = 3; remain = D; end
        3: if (!l2) begin phase = 2; restarted = 1; end
           else if (remain == 1) phase = 4;
           else remain--;
        default: if (!l2) begin phase = 2; dropped = 1; end
      endcase
      b2 = b1; b1 = busy_in;
      l2 = l1; l1 = lock_in;
    end
  endtask

  task automatic compare();
    logic [2:0] act, exp_v;
    act = {rx_analog_rst, rx_digital_rst, rx_ready};
    exp_v = expect_out(phase);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: {analog,digital,ready} actual=%b expected=%b at %0t",
               tag_of(phase, in_rst, from_guard, restarted, dropped), act, exp_v, $time);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  // One episode: reset, then busy_hi cycles of busy, lock after lock_at cycles,
  // lock drop chance 1/drop_div per cycle (0 = never), busy reconfig pulse chance.
  task automatic episode(int busy_hi, int lock_at, int drop_div, int pulse_div, int len);
    int drop_left = 0;
    int busy_left = 0;
    @(negedge clk);
    rst_req = 1;
    busy_in = $urandom_range(0, 1);
    lock_in = $urandom_range(0, 1);
    repeat (3) cycle();
    rst_req = 0;
    for (int c = 0; c < len; c++) begin
      if (c < busy_hi) busy_in = 1;
      else if (busy_left > 0) begin busy_in = 1; busy_left--; end
      else begin
        busy_in = 0;
        if (pulse_div > 0 && $urandom_range(0, pulse_div - 1) == 0) busy_left = $urandom_range(0, 2);
      end
      if (c < lock_at) lock_in = 0;
      else if (drop_left > 0) begin lock_in = 0; drop_left--; end
      else begin
        lock_in = 1;
        if (drop_div > 0 && $urandom_range(0, drop_div - 1) == 0) drop_left = $urandom_range(1, 3);
      end
      cycle();
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R8: reset state before any sequence
    repeat (2) cycle();
    // Directed: busy low from the start, lock present early (R2, R4)
    episode(0, 0, 0, 0, 60);
    // Directed: long calibration, lock late (R1, R3)
    episode(15, 40, 0, 0, 90);
    // Directed: busy pulses during guard (R9)
    episode(3, 30, 0, 3, 80);
    // Directed: lock glitches during dwell and while ready (R5, R6)
    episode(2, 10, 12, 0, 150);
    // Directed: reset request while ready (R8)
    episode(0, 0, 0, 0, 40);
    episode(0, 0, 0, 0, 10);
    // Constrained random episodes
    for (int e = 0; e < 40; e++)
      episode($urandom_range(0, 12), $urandom_range(0, 40),
              ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(8, 60),
              ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(3, 20),
              $urandom_range(30, 160));
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule